// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block times and controls an 8-bit successive-approximation converter. It decides when the sampling switch closes, runs a binary search one bit per clock against a 1-bit comparator decision, latches the coded result and reports completion. The comparator, the sampling capacitor, the trial DAC and the clock source all sit outside the block. The block drives their controls (`sample_o`, `dac_code_o`, `cmp_en_o`, `clk_buf_en_o`) and reads back only the comparator bit `cmp_i`.

A conversion can start in two ways. In pin-start mode the start pin sets the length of the sampling window. In strobe-start mode the write strobe launches the first sample, and each later read of the result launches the next one. The block enters a low-power state of its own accord when a result is left unread. It is forced into a deeper power-down when chip select is held inactive. All strobes are active low and are sampled on the rising clock edge. A "rising edge" of a strobe is seen at the first clock edge where the strobe is high after being low at the edge before.

Top module: `sar_seq`

## Requirements
- R1: In strobe-start mode (`cfg_sw_start_i`=1) `result_o` takes the new value exactly 16 clock edges after the edge that sees the trigger. It keeps its old value one edge earlier.
- R2: In strobe-start mode `sample_o` is high for exactly 6 cycles, beginning in the cycle after the trigger edge.
- R3: In pin-start mode (`cfg_sw_start_i`=0) a falling `start_ni` raises `sample_o`, which stays high while the pin is low, even beyond 6 cycles. The rising edge of `start_ni` ends sampling, and the result appears 10 edges after that rising edge.
- R4: In strobe-start mode the first conversion after reset is launched only by a `wr_ni` rising edge, and a `rd_ni` rising edge before it is ignored. Once a conversion has completed, a `rd_ni` rising edge launches the next one.
- R5: With `cfg_eoc_mode_i`=0, `status_o` is low except for a one-cycle high pulse in the cycle when the new result first appears.
- R6: With `cfg_eoc_mode_i`=1, `status_o` is high while idle or sampling. It goes low when sampling ends and returns high in the cycle the new result appears.
- R7: The search tests bits MSB first, one per clock, and `dac_code_o` shows the trial code. The first trial is 8'h80, and a bit is kept when `cmp_i`=1 (input at or above trial). A comparator that is always 1 yields 8'hFF, and one that is always 0 yields 8'h00.
- R8: With `cfg_twos_i`=1 the stored result is the binary code with bit 7 inverted (8'h80 becomes 8'h00, 8'h7F becomes 8'hFF).
- R9: If no `rd_ni` rising edge is seen at the edge after the result appears, `cmp_en_o` and `clk_buf_en_o` go low. A later trigger restores them in the first sampling cycle. A timely read keeps them high.
- R10: When `cs_ni` is seen high at two consecutive edges, the block powers down at the second edge, aborts any conversion and drops both enables. When `cs_ni` is seen low at two consecutive edges, it returns to idle with the enables high. While `cs_ni` is high, strobes start nothing and the result is unchanged.
- R11: A trigger that arrives while sampling or converting is ignored, and the conversion timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low; held high forces power-down |
| start_ni | input | 1 | Hardware start pin |
| wr_ni | input | 1 | Write strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| cfg_sw_start_i | input | 1 | 1: strobe-start mode, 0: pin-start mode |
| cfg_eoc_mode_i | input | 1 | 1: level end-of-conversion, 0: one-clock pulse |
| cfg_twos_i | input | 1 | 1: two's-complement result |
| cmp_i | input | 1 | Comparator decision, 1 when input is at or above trial |
| sample_o | output | 1 | Sampling switch control |
| cmp_en_o | output | 1 | Comparator enable |
| clk_buf_en_o | output | 1 | Clock buffer enable |
| dac_code_o | output | 8 | Trial code for the DAC |
| result_o | output | 8 | Latched conversion result |
| status_o | output | 1 | Completion pulse or end-of-conversion level |

## Verification
Some rules hold on every cycle and are checked there: the strobe-start sampling window is six cycles long, the completion pulse lasts one clock, the result changes only while completion is signalled, no conversion is flagged while sampling, an unread result leads to power-down, and a held-high chip select drops both enables. The exact 16-clock and 10-clock latencies are shown only by the bench's scenarios. So are the bit-by-bit trial codes and the search results for full scale, zero and random inputs, including two's-complement coding. The scenarios also cover the choice between write and read triggers, triggers ignored mid-conversion, and recovery from either power-down.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    ST_READY,
    ST_SAMPLE,
    ST_SETTLE,
    ST_STEP,
    ST_LATCH,
    ST_WAIT,
    ST_APD,
    ST_SPD
  } seq_state_e;
endpackage

// File: rtl/sar_strobe_edges.sv
module sar_strobe_edges (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_ni,
  input  logic wr_ni,
  input  logic rd_ni,
  input  logic cs_ni,
  output logic start_fall_o,
  output logic start_rise_o,
  output logic wr_rise_o,
  output logic rd_rise_o,
  output logic cs_prev_o
);
  logic [3:0] cur, prev_q;

  assign cur = {cs_ni, rd_ni, wr_ni, start_ni};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= cur;
  end

  assign start_fall_o = prev_q[0] & ~cur[0];
  assign start_rise_o = ~prev_q[0] & cur[0];
  assign wr_rise_o    = ~prev_q[1] & cur[1];
  assign rd_rise_o    = ~prev_q[2] & cur[2];
  assign cs_prev_o    = prev_q[3];
endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] sar_o,
  output logic             last_o
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] sar_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sar_q  <= '0;
      mask_q <= '0;
    end else if (clear_i) begin
      sar_q  <= '0;
      mask_q <= TOP_BIT;
    end else if (step_i) begin
      if (cmp_i) sar_q <= sar_q | mask_q;
      mask_q <= mask_q >> 1;
    end
  end

  assign trial_o = sar_q | mask_q;
  assign sar_o   = sar_q;
  assign last_o  = mask_q[0];
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_seq_pkg::*;
#(
  parameter int SAMPLE_CYC = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sw_mode_i,
  input  logic       cs_ni,
  input  logic       cs_prev_i,
  input  logic       start_fall_i,
  input  logic       start_rise_i,
  input  logic       wr_rise_i,
  input  logic       rd_rise_i,
  input  logic       last_i,
  output seq_state_e state_o
);
  localparam int CNT_W = (SAMPLE_CYC > 1) ? $clog2(SAMPLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SAMPLE_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q;
  logic             sel, go, spd_in, spd_out;

  assign sel     = ~cs_ni;
  assign go      = sel & (sw_mode_i ? (wr_rise_i | (rd_rise_i & armed_q)) : start_fall_i);
  assign spd_in  = cs_ni & cs_prev_i;
  assign spd_out = ~cs_ni & ~cs_prev_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = '0;
    if (spd_in && state_q != ST_SPD) begin
      state_d = ST_SPD;
    end else begin
      unique case (state_q)
        ST_READY:  if (go) state_d = ST_SAMPLE;
        ST_SAMPLE: begin
          if (sw_mode_i) begin
            if (cnt_q == CNT_END) state_d = ST_SETTLE;
            else                  cnt_d   = cnt_q + 1'b1;
          end else if (start_rise_i) begin
            state_d = ST_SETTLE;
          end
        end
        ST_SETTLE: state_d = ST_STEP;
        ST_STEP:   if (last_i) state_d = ST_LATCH;
        ST_LATCH:  state_d = ST_WAIT;
        ST_WAIT: begin
          if (go)                     state_d = ST_SAMPLE;
          else if (sel && rd_rise_i)  state_d = ST_READY;
          else                        state_d = ST_APD;
        end
        ST_APD: begin
          if (go)                     state_d = ST_SAMPLE;
          else if (sel && rd_rise_i)  state_d = ST_READY;
        end
        ST_SPD:    if (spd_out) state_d = ST_READY;
        default:   state_d = ST_READY;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_READY;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (state_q == ST_LATCH) armed_q <= 1'b1;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int SAMPLE_CYC = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             start_ni,
  input  logic             wr_ni,
  input  logic             rd_ni,
  input  logic             cfg_sw_start_i,
  input  logic             cfg_eoc_mode_i,
  input  logic             cfg_twos_i,
  input  logic             cmp_i,
  output logic             sample_o,
  output logic             cmp_en_o,
  output logic             clk_buf_en_o,
  output logic [WIDTH-1:0] dac_code_o,
  output logic [WIDTH-1:0] result_o,
  output logic             status_o
);
  localparam logic [WIDTH-1:0] SIGN_FLIP = {1'b1, {(WIDTH-1){1'b0}}};

  seq_state_e       state;
  logic             start_fall, start_rise, wr_rise, rd_rise, cs_prev;
  logic             last_step;
  logic [WIDTH-1:0] sar;
  logic [WIDTH-1:0] result_q;
  logic             pulse_q;
  logic             in_conv, powered;

  sar_strobe_edges i_edges (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_ni     (start_ni),
    .wr_ni        (wr_ni),
    .rd_ni        (rd_ni),
    .cs_ni        (cs_ni),
    .start_fall_o (start_fall),
    .start_rise_o (start_rise),
    .wr_rise_o    (wr_rise),
    .rd_rise_o    (rd_rise),
    .cs_prev_o    (cs_prev)
  );

  sar_ctrl #(.SAMPLE_CYC(SAMPLE_CYC)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sw_mode_i    (cfg_sw_start_i),
    .cs_ni        (cs_ni),
    .cs_prev_i    (cs_prev),
    .start_fall_i (start_fall),
    .start_rise_i (start_rise),
    .wr_rise_i    (wr_rise),
    .rd_rise_i    (rd_rise),
    .last_i       (last_step),
    .state_o      (state)
  );

  sar_core #(.WIDTH(WIDTH)) i_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (state == ST_SETTLE),
    .step_i  (state == ST_STEP),
    .cmp_i   (cmp_i),
    .trial_o (dac_code_o),
    .sar_o   (sar),
    .last_o  (last_step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      pulse_q  <= 1'b0;
    end else begin
      pulse_q <= (state == ST_LATCH) & ~cfg_eoc_mode_i;
      if (state == ST_LATCH) result_q <= sar ^ (cfg_twos_i ? SIGN_FLIP : '0);
    end
  end

  assign in_conv      = (state == ST_SETTLE) || (state == ST_STEP) || (state == ST_LATCH);
  assign powered      = (state != ST_APD) && (state != ST_SPD);
  assign sample_o     = (state == ST_SAMPLE);
  assign cmp_en_o     = powered;
  assign clk_buf_en_o = powered;
  assign result_o     = result_q;
  assign status_o     = cfg_eoc_mode_i ? ~in_conv : pulse_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int WIDTH      = 8,
  parameter int SAMPLE_CYC = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             start_ni,
  input logic             wr_ni,
  input logic             rd_ni,
  input logic             cfg_sw_start_i,
  input logic             cfg_eoc_mode_i,
  input logic             sample_o,
  input logic             cmp_en_o,
  input logic             clk_buf_en_o,
  input logic [WIDTH-1:0] result_o,
  input logic             status_o
);
  localparam int CW = $clog2(SAMPLE_CYC + 1) + 1;

  logic [CW-1:0] smp_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       smp_cnt <= '0;
    else if (sample_o) smp_cnt <= smp_cnt + 1'b1;
    else               smp_cnt <= '0;
  end

  a_r2_sample_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sample_o) && cmp_en_o && cfg_sw_start_i) |-> (smp_cnt == CW'(SAMPLE_CYC)));

  a_r5_pulse_one_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_eoc_mode_i && status_o) |=> (cfg_eoc_mode_i || !status_o));

  a_r1_result_with_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> status_o);

  a_r6_eoc_high_sampling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_eoc_mode_i && sample_o) |-> status_o);

  a_r9_auto_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_eoc_mode_i && status_o && !(rd_ni && !$past(rd_ni)) &&
     !(wr_ni && !$past(wr_ni)) && !(!start_ni && $past(start_ni)))
    |=> (!cmp_en_o && !clk_buf_en_o));

  a_r10_spd_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni)) |=> (!cmp_en_o && !clk_buf_en_o));
endmodule

bind sar_seq sar_seq_chk #(.WIDTH(WIDTH), .SAMPLE_CYC(SAMPLE_CYC)) i_sar_seq_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cs_ni          (cs_ni),
  .start_ni       (start_ni),
  .wr_ni          (wr_ni),
  .rd_ni          (rd_ni),
  .cfg_sw_start_i (cfg_sw_start_i),
  .cfg_eoc_mode_i (cfg_eoc_mode_i),
  .sample_o       (sample_o),
  .cmp_en_o       (cmp_en_o),
  .clk_buf_en_o   (clk_buf_en_o),
  .result_o       (result_o),
  .status_o       (status_o)
);

// File: tb/test_sar_seq.sv
`timescale 1ns/1ps
module test_sar_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b0, start_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic       sw = 1'b1, eoc = 1'b0, twos = 1'b0;
  logic [7:0] ain = 8'h00;
  logic       cmp;
  logic       sample, cmp_en, clk_buf_en, status;
  logic [7:0] dac, result;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  assign cmp = (ain >= dac);

  sar_seq i_sar_seq (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .start_ni(start_n),
    .wr_ni(wr_n), .rd_ni(rd_n), .cfg_sw_start_i(sw), .cfg_eoc_mode_i(eoc),
    .cfg_twos_i(twos), .cmp_i(cmp), .sample_o(sample), .cmp_en_o(cmp_en),
    .clk_buf_en_o(clk_buf_en), .dac_code_o(dac), .result_o(result), .status_o(status)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] coded(input logic [7:0] a, input logic t);
    return t ? (a ^ 8'h80) : a;
  endfunction

  task automatic sw_conv(input bit by_rd, input logic [7:0] a, input bit t,
                         input bit lvl, input bit noisy);
    logic [7:0] old;
    @(negedge clk);
    sw = 1'b1; eoc = lvl; twos = t; ain = a;
    old = result;
    if (by_rd) rd_n = 1'b0; else wr_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1;
    for (int j = 0; j <= 17; j++) begin
      @(negedge clk);
      if (j == 0) begin
        chk("R2 sample first cycle", sample, 1);
        chk("R9 enables on resume", cmp_en & clk_buf_en, 1);
      end
      if (j == 5) begin
        chk("R2 sample sixth cycle", sample, 1);
        if (lvl) chk("R6 status high while sampling", status, 1);
      end
      if (j == 6) begin
        chk("R2 sample ends", sample, 0);
        if (lvl) chk("R6 status low at conversion", status, 0);
      end
      if (j == 7) chk("R7 first trial", dac, 8'h80);
      if (j == 8) chk("R7 second trial", dac, (a >= 8'h80) ? 8'hC0 : 8'h40);
      if (j == 15) begin
        chk("R1 result not yet", result, old);
        chk(lvl ? "R6 status low" : "R5 status low", status, 0);
      end
      if (j == 16) begin
        chk("R1 R8 result", result, coded(a, t));
        chk(lvl ? "R6 status returns" : "R5 pulse", status, 1);
      end
      if (j == 17) begin
        if (!lvl) chk("R5 pulse one clock", status, 0);
        chk("R9 auto power-down", cmp_en | clk_buf_en, 0);
      end
      if (noisy) begin  // R11 triggers mid-conversion
        if (j == 2)  begin wr_n = 1'b0; rd_n = 1'b0; end
        if (j == 3)  begin wr_n = 1'b1; rd_n = 1'b1; end
        if (j == 9)  rd_n = 1'b0;
        if (j == 10) rd_n = 1'b1;
      end
    end
  endtask

  task automatic hw_conv(input logic [7:0] a, input int hold, input bit read_now);
    logic [7:0] old;
    @(negedge clk);
    sw = 1'b0; eoc = 1'b0; twos = 1'b0; ain = a;
    old = result;
    start_n = 1'b0;
    for (int j = 0; j < hold; j++) begin
      @(negedge clk);
      if (j == 0) chk("R3 sampling on falling pin", sample, 1);
      if (j == hold - 1) chk("R3 extended sampling", sample, 1);
    end
    start_n = 1'b1;
    for (int j = 0; j <= 11; j++) begin
      @(negedge clk);
      if (j == 0) chk("R3 sampling ends on rising pin", sample, 0);
      if (j == 9) begin
        chk("R3 result not yet", result, old);
        if (read_now) rd_n = 1'b0;
      end
      if (j == 10) begin
        chk("R3 result", result, a);
        rd_n = 1'b1;
      end
      if (j == 11) chk("R9 enables after read", cmp_en, read_now ? 1 : 0);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset result", result, 0);
    chk("R2 reset sample", sample, 0);
    chk("R9 reset enables", cmp_en & clk_buf_en, 1);
    chk("R5 reset status", status, 0);

    // R4 read before any conversion is ignored
    rd_n = 1'b0; @(negedge clk); rd_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R4 early read ignored", sample, 0);

    sw_conv(1'b0, 8'hFF, 1'b0, 1'b0, 1'b0);  // R7 full scale via write (R4)
    sw_conv(1'b1, 8'h00, 1'b0, 1'b1, 1'b0);  // R7 zero via read (R4)
    sw_conv(1'b1, 8'h80, 1'b1, 1'b0, 1'b1);  // R8 and R11
    sw_conv(1'b0, 8'h7F, 1'b1, 1'b1, 1'b1);  // R8

    hw_conv(8'hA5, 9, 1'b0);
    hw_conv(8'h3C, 2, 1'b1);

    // R10 forced power-down mid-conversion
    @(negedge clk);
    sw = 1'b1; eoc = 1'b0; twos = 1'b0; ain = 8'h55;
    begin
      logic [7:0] old;
      old = result;
      rd_n = 1'b0; @(negedge clk); rd_n = 1'b1;
      for (int j = 0; j <= 8; j++) begin
        @(negedge clk);
        if (j == 8) cs_n = 1'b1;
      end
      @(negedge clk);
      chk("R10 one high edge keeps power", cmp_en, 1);
      @(negedge clk);
      chk("R10 power-down entered", cmp_en | clk_buf_en, 0);
      wr_n = 1'b0; @(negedge clk); wr_n = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R10 strobe ignored while deselected", sample, 0);
      chk("R10 result unchanged", result, old);
      cs_n = 1'b0;
      @(negedge clk);
      chk("R10 exit needs two edges", cmp_en, 0);
      @(negedge clk);
      chk("R10 exit", cmp_en & clk_buf_en, 1);
    end

    for (int i = 0; i < 10; i++) begin
      sw_conv(1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule